// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts scanline ticks downward from a value the CPU programs and raises a level interrupt request when the count passes below zero. The CPU talks to it through four write-only commands. The command is picked by the write address after it is masked with 0xE001. The four commands are: store a preset value, copy the preset into the counter, disarm and acknowledge, and arm. A separate single-cycle `line_tick` pulse advances the counter once per scanline. The interrupt stays asserted until it is acknowledged or the block is reset.

Two hidden flags decide when the preset reaches the counter. A *quick-load* flag is set by a disarm command and cleared by the next tick. While it is set, a preset write goes straight into the counter. A *pending-preset* flag is set by a normal preset write, and while it is set an arm command reloads the counter. After it underflows, the counter parks and does not wrap. It counts again only after a reload.

The counter is a two-state machine. State `CNT_LIVE` means the count is zero or above. State `CNT_SPENT` means it has gone below zero. The transitions are:
- `LIVE->LIVE`: a tick with a count above zero decrements it.
- `LIVE->SPENT`: an underflow, which is a tick at count zero.
- `SPENT->SPENT`: ticks are ignored.
- `any->LIVE`: a load from a preset write in quick-load mode, a reload command, or an arm command with a pending preset.

Top module: `scan_irq_counter`

## Requirements
- R1: A write acts only when (cpu_addr & 0xE001) equals 0xC000 (preset), 0xC001 (reload), 0xE000 (disarm/acknowledge) or 0xE001 (arm). Any other address has no effect, and mirrored addresses such as 0xDFFE act like their masked value.
- R2: A preset write outside quick-load mode stores cpu_wdata as the preset, sets the pending-preset flag and leaves the counter unchanged.
- R3: A preset write in quick-load mode loads cpu_wdata into the counter at once and clears the pending-preset flag.
- R4: A reload write copies the stored preset into the counter.
- R5: A disarm write clears the enable and the interrupt request and sets quick-load mode.
- R6: An arm write sets the enable. If the pending-preset flag is set, the arm write also reloads the counter from the preset. The interrupt is raised only while the block is enabled.
- R7: Every tick clears quick-load mode.
- R8: A tick with count N ≥ 1 makes the count N−1. A tick at count 0 underflows and sets irq_req one cycle later if the block is enabled. After loading N, the (N+1)th tick raises the interrupt.
- R9: Once underflowed, the counter ignores ticks and raises no further interrupt until it is reloaded.
- R10: irq_req stays high until a disarm write or a reset.
- R11: When a write and a tick occur in the same cycle, the write takes effect first and the tick then acts on the result.
- R12: Reset clears the counter, the preset, the enable, both flags and irq_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 16 | Write address |
| cpu_wdata | input | 8 | Write data |
| line_tick | input | 1 | One-cycle scanline pulse |
| irq_req | output | 1 | Level interrupt request |

## Verification
The hardest behaviour to reach is the interplay of the two hidden flags. Telling a quick-load preset apart from an arm-triggered reload needs a disarm, then a preset, then a tick, then an arm, in that order, and the result shows up only in how many ticks pass before the interrupt. Directed sequences build exactly those orderings, along with write-and-tick collisions in one cycle. Random traffic then weights the addresses toward the four command values and keeps the data small, so that underflows, reloads and acknowledges interleave often.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    localparam logic [15:0] DEC_MASK    = 16'hE001;
    localparam logic [15:0] ADR_PRESET  = 16'hC000;
    localparam logic [15:0] ADR_RELOAD  = 16'hC001;
    localparam logic [15:0] ADR_DISARM  = 16'hE000;
    localparam logic [15:0] ADR_ARM     = 16'hE001;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PRESET,
        CMD_RELOAD,
        CMD_DISARM,
        CMD_ARM
    } cmd_e;

    typedef enum logic {
        CNT_LIVE,
        CNT_SPENT
    } cnt_state_e;

endpackage

// File: rtl/sirq_cmd_decode.sv
module sirq_cmd_decode
    import scan_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd
);
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'(DEC_MASK);

    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked = addr & MASK;
        cmd    = CMD_NONE;
        if (we) begin
            unique case (masked)
                ADDR_W'(ADR_PRESET): cmd = CMD_PRESET;
                ADDR_W'(ADR_RELOAD): cmd = CMD_RELOAD;
                ADDR_W'(ADR_DISARM): cmd = CMD_DISARM;
                ADDR_W'(ADR_ARM):    cmd = CMD_ARM;
                default:             cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sirq_ctrl_regs.sv
module sirq_ctrl_regs
    import scan_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic              load_req,
    output logic [DATA_W-1:0] load_val,
    output logic              en_post,
    output logic              ack,
    output logic              en_q
);
    logic [DATA_W-1:0] preset_q, preset_d;
    logic              quick_q, quick_d;
    logic              pend_q, pend_d;
    logic              en_d;

    // write effects first; the tick then only clears quick-load mode
    always_comb begin
        preset_d = preset_q;
        quick_d  = quick_q;
        pend_d   = pend_q;
        en_d     = en_q;
        load_req = 1'b0;
        load_val = preset_q;
        ack      = 1'b0;
        unique case (cmd)
            CMD_PRESET: begin
                preset_d = wdata;
                load_val = wdata;
                if (quick_q) begin
                    load_req = 1'b1;
                    pend_d   = 1'b0;
                end else begin
                    pend_d   = 1'b1;
                end
            end
            CMD_RELOAD: load_req = 1'b1;
            CMD_DISARM: begin
                en_d    = 1'b0;
                ack     = 1'b1;
                quick_d = 1'b1;
            end
            CMD_ARM: begin
                en_d     = 1'b1;
                load_req = pend_q;
            end
            default: ;
        endcase
        if (tick) quick_d = 1'b0;
        en_post = en_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
            quick_q  <= 1'b0;
            pend_q   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            preset_q <= preset_d;
            quick_q  <= quick_d;
            pend_q   <= pend_d;
            en_q     <= en_d;
        end
    end
endmodule

// File: rtl/sirq_counter_fsm.sv
module sirq_counter_fsm
    import scan_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick,
    input  logic              en_post,
    input  logic              ack,
    output logic              irq_req,
    output logic              spent
);
    cnt_state_e        state_q, state_d, base_state;
    logic [DATA_W-1:0] cnt_q, cnt_d, base_cnt;
    logic              underflow;
    logic              irq_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_LIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: a load applies first, the tick acts on the loaded value
    always_comb begin
        base_state = load_req ? CNT_LIVE : state_q;
        base_cnt   = load_req ? load_val : cnt_q;
        state_d    = base_state;
        cnt_d      = base_cnt;
        underflow  = 1'b0;
        unique case (base_state)
            CNT_LIVE: begin
                if (tick) begin
                    if (base_cnt == '0) begin
                        state_d   = CNT_SPENT;
                        underflow = 1'b1;
                    end else begin
                        cnt_d = base_cnt - 1'b1;
                    end
                end
            end
            CNT_SPENT: ;
            default: state_d = CNT_LIVE;
        endcase
    end

    // outputs
    always_comb irq_d = (irq_req && !ack) || (underflow && en_post);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= irq_d;
    end

    assign spent = (state_q == CNT_SPENT);
endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter
    import scan_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              line_tick,
    output logic              irq_req
);
    cmd_e              cmd;
    logic              load_req;
    logic [DATA_W-1:0] load_val;
    logic              en_post;
    logic              ack;
    logic              en_q;
    logic              spent;

    sirq_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we   (cpu_we),
        .addr (cpu_addr),
        .cmd  (cmd)
    );

    sirq_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .wdata    (cpu_wdata),
        .tick     (line_tick),
        .load_req (load_req),
        .load_val (load_val),
        .en_post  (en_post),
        .ack      (ack),
        .en_q     (en_q)
    );

    sirq_counter_fsm #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .load_val (load_val),
        .tick     (line_tick),
        .en_post  (en_post),
        .ack      (ack),
        .irq_req  (irq_req),
        .spent    (spent)
    );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
    import scan_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              line_tick,
    input logic              irq_req,
    input logic              en_q,
    input logic              spent
);
    logic disarm_wr, arm_wr;
    assign disarm_wr = cpu_we && ((cpu_addr & ADDR_W'(DEC_MASK)) == ADDR_W'(ADR_DISARM));
    assign arm_wr    = cpu_we && ((cpu_addr & ADDR_W'(DEC_MASK)) == ADDR_W'(ADR_ARM));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_wr |=> !irq_req);

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !disarm_wr) |=> irq_req);

    p_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(line_tick));

    p_rise_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(en_q || arm_wr));

    p_spent_parks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spent && !cpu_we) |=> spent);

    p_reset_clears_r12: assert property (@(posedge clk)
        !rst_n |=> !irq_req);
endmodule

bind scan_irq_counter sirq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .line_tick (line_tick),
    .irq_req   (irq_req),
    .en_q      (en_q),
    .spent     (spent)
);

// File: tb/sim_scan_irq_counter.sv
module sim_scan_irq_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        line_tick = 1'b0;
    logic        irq_req;

    int checks = 0;
    int failures = 0;

    // reference model
    int m_cnt, m_preset;
    bit m_en, m_quick, m_pend, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_irq_counter u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .line_tick(line_tick), .irq_req(irq_req)
    );

    function automatic logic [15:0] masked(input logic [15:0] a);
        return a & 16'hE001;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_preset = 0; m_en = 0; m_quick = 0; m_pend = 0; m_irq = 0;
    endtask

    task automatic model_step(input bit we, input logic [15:0] a,
                              input logic [7:0] d, input bit t);
        if (we) begin
            case (masked(a))
                16'hC000: begin
                    m_preset = d;
                    if (m_quick) begin m_cnt = d; m_pend = 0; end
                    else m_pend = 1;
                end
                16'hC001: m_cnt = m_preset;
                16'hE000: begin m_en = 0; m_irq = 0; m_quick = 1; end
                16'hE001: begin m_en = 1; if (m_pend) m_cnt = m_preset; end
                default: ;
            endcase
        end
        if (t) begin
            m_quick = 0;
            if (m_cnt >= 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt < 0 && m_en) m_irq = 1;
            end
        end
    endtask

    task automatic check_irq(input string tag, input bit exp);
        checks++;
        if (irq_req !== exp) begin
            failures++;
            $display("FAIL %s irq_req actual=%0b expected=%0b at %0t", tag, irq_req, exp, $time);
        end
    endtask

    task automatic step(input bit we, input logic [15:0] a, input logic [7:0] d,
                        input bit t, input string tag);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d; line_tick = t;
        model_step(we, a, d, t);
        @(posedge clk);
        #1;
        check_irq(tag, m_irq);
        cpu_we = 1'b0; line_tick = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic tk(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 8'h00, 1'b1, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        #1;
        check_irq("R12", 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5CA1_1E05));
        model_reset();
        do_reset();

        // R12: counter starts at zero, so arm and one tick underflow at once
        wr(16'hE001, 8'h00, "R12");
        tk(1, "R12");
        check_irq("R12", 1'b1);
        // R10: sticky across ticks and a reload
        tk(3, "R10");
        wr(16'hC001, 8'h00, "R10");
        check_irq("R10", 1'b1);
        // R5: disarm acknowledges
        wr(16'hE000, 8'h00, "R5");
        check_irq("R5", 1'b0);

        // R7, R2, R6, R8: tick leaves quick-load mode, preset 5 pends, arm reloads
        tk(1, "R7");
        wr(16'hC000, 8'd5, "R2");
        wr(16'hE001, 8'h00, "R6");
        tk(5, "R8");
        check_irq("R8", 1'b0);
        tk(1, "R8");
        check_irq("R8", 1'b1);

        // R3: quick-load preset 3, tick to 2, arm without reload -> irq on 3rd tick
        wr(16'hE000, 8'h00, "R3");
        wr(16'hC000, 8'd3, "R3");
        tk(1, "R3");
        wr(16'hE001, 8'h00, "R3");
        tk(2, "R3");
        check_irq("R3", 1'b0);
        tk(1, "R3");
        check_irq("R3", 1'b1);

        // R4: reload command copies preset
        wr(16'hE000, 8'h00, "R4");
        tk(1, "R4");
        wr(16'hC000, 8'd2, "R4");
        wr(16'hC001, 8'h00, "R4");
        wr(16'hE001, 8'h00, "R4");
        tk(3, "R4");
        check_irq("R4", 1'b1);

        // R9: underflow while disarmed, then arm without reload: stays quiet
        wr(16'hE000, 8'h00, "R9");
        wr(16'hC000, 8'd1, "R9");
        tk(2, "R9");
        wr(16'hE001, 8'h00, "R9");
        tk(4, "R9");
        check_irq("R9", 1'b0);

        // R11: arm with pending preset 0 and a tick in the same cycle
        wr(16'hE000, 8'h00, "R11");
        tk(1, "R11");
        wr(16'hC000, 8'd0, "R11");
        step(1'b1, 16'hE001, 8'h00, 1'b1, "R11");
        check_irq("R11", 1'b1);
        // R11: disarm plus tick in one cycle keeps irq low
        step(1'b1, 16'hE000, 8'h00, 1'b1, "R11");
        check_irq("R11", 1'b0);

        // R1: unmapped addresses ignored, mirrored address acts
        wr(16'h6000, 8'h00, "R1");
        wr(16'hA001, 8'h00, "R1");
        wr(16'h8001, 8'h00, "R1");
        tk(3, "R1");
        check_irq("R1", 1'b0);
        wr(16'hDFFE, 8'd1, "R1");
        wr(16'hFFFF, 8'h00, "R1");
        tk(2, "R1");
        check_irq("R1", 1'b1);

        // R12: reset mid-run with irq pending
        do_reset();
        wr(16'hE001, 8'h00, "R12");
        tk(1, "R12");
        check_irq("R12", 1'b1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int sel;
            sel = $urandom_range(0, 5);
            case (sel)
                0: a = 16'hC000;
                1: a = 16'hC001;
                2: a = 16'hE000;
                3: a = 16'hE001;
                4: a = 16'hC000 | 16'($urandom_range(0, 16'h1FFE)) & 16'hFFFE;
                default: a = 16'($urandom);
            endcase
            step(($urandom_range(0, 1) == 1), a, 8'($urandom_range(0, 7)),
                 ($urandom_range(0, 2) == 0), "R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule